// File: doc/BRIEF.md
# Direct and Duplex LCD Drive Waveform Generator

This block turns a small bank of segment pixel registers into the digital drive codes for a liquid crystal panel. It holds eight 8-bit segment registers, forms 32 segment outputs and two backplane outputs, and advances its drive waveform one phase for each pulse of a frame-rate clock enable. Every output is a 2-bit level code. An external analog stage turns each code into a real voltage: the low rail, the mid point, the high rail or a floating pin.

Two drive schemes are supported. In direct drive, one backplane toggles between the rails and each segment is driven either with it or against it. Even and odd registers form two separate display pages, and a page select input picks one of them. In duplex drive, two backplanes take turns being active while the idle one rests at the mid level. Even registers then carry the pixels of the first backplane and odd registers carry those of the second, which produces the 0.791 / 0.354 RMS ratio of a half-biased two-way multiplex.

Several of these blocks can share one set of backplanes. A follower instance leaves its backplane pins floating and takes its waveform phase from the backplane levels driven by the leader.

Top module: `lcd_wave_gen`

## Requirements
- R1: Level codes are 00 = low rail, 01 = mid level, 10 = high rail, 11 = floating. While reset is held and in the cycle after it, every segment output is 00. Each backplane output is 00 when the follower input is low and 11 when it is high. All eight registers read as zero after reset.
- R2: In direct drive (mode input 0), the first backplane is 10 in phase 0 and 00 in every other phase. Each frame tick alternates between phase 0 and phase 1. The second backplane stays at 00.
- R3: In direct drive, a segment whose pixel bit is 1 takes the rail opposite the first backplane, and a segment whose pixel bit is 0 takes the same rail.
- R4: Register 2k (page 0) and register 2k+1 (page 1) both map to segments 8k to 8k+7, with bit j driving segment 8k+j (segment i occupies output bits 2i+1:2i). In direct drive the page input picks the even registers (0) or the odd registers (1).
- R5: In duplex drive (mode input 1), phases 0 to 3 repeat in order. Phase 0 puts the first backplane at 10 and phase 1 puts it at 00, with the second backplane at 01 in both. Phase 2 puts the second backplane at 10 and phase 3 puts it at 00, with the first backplane at 01 in both. The two backplanes are never both at 01.
- R6: In duplex drive, phases 0 and 1 show the even registers and phases 2 and 3 show the odd registers. A pixel bit of 1 takes the rail opposite the active backplane, and a pixel bit of 0 takes the same rail. The page input has no effect, and segment outputs are never 01 or 11.
- R7: Mode and page inputs are sampled only when the phase advances. Segment outputs change only in the cycle after an advance, so a phase is never shown in part.
- R8: A register write changes no output until the next phase advance. At that advance, the new register contents are displayed.
- R9: With the follower input high, both backplane outputs are 11 and frame ticks are ignored. The phase comes from the external backplane inputs, checked in this order: first at 10 gives phase 0, first at 00 gives phase 1, second at 10 gives phase 2, second at 00 gives phase 3. Any other combination holds the phase. A new phase is taken one clock after it appears on the external inputs.
- R10: The first advance after reset enters phase 0. In direct drive, an advance from any phase other than 0 enters phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frameTick | input | 1 | One-cycle pulse that advances the phase when the block leads |
| cascadeIn | input | 1 | High selects follower operation |
| extBp1Lvl | input | 2 | Level code of the leader's first backplane |
| extBp2Lvl | input | 2 | Level code of the leader's second backplane |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register index for a write |
| wrData | input | 8 | Pixel byte to write |
| modeIn | input | 1 | 0 direct drive, 1 duplex drive |
| bankIn | input | 1 | Page select in direct drive |
| segLvl | output | 64 | Level codes of the 32 segments, segment i at bits 2i+1:2i |
| bp1Lvl | output | 2 | Level code of the first backplane |
| bp2Lvl | output | 2 | Level code of the second backplane |

## Verification
The bench builds the block with its default four register pairs of eight bits. At this size every one of the 32 segments and all eight registers can be observed, so the page swap, the pair-to-segment mapping and the duplex split between even and odd registers are all checked across the full width. A behavioural model predicts every output in every clock through direct drive on both pages, duplex drive with page toggles, a mode switch from a late duplex phase, and follower operation driven by each external phase pattern, including the floating pattern that holds the phase.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

  // Digital level codes handed to the analog output stage
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_HIZ  = 2'b11
  } lvl_e;

  // Strobes from phase control to the segment datapath
  typedef struct packed {
    logic       advance;  // load a new phase at this edge
    logic [1:0] phase;    // phase being entered
    logic       duplex;   // drive scheme for that phase
    logic       bank;     // page select for that phase (direct only)
  } phase_strobe_t;

  // Opposite rail; mid and floating pass through unchanged
  function automatic lvl_e flipRail(input lvl_e l);
    case (l)
      LVL_HIGH: flipRail = LVL_LOW;
      LVL_LOW:  flipRail = LVL_HIGH;
      default:  flipRail = l;
    endcase
  endfunction

endpackage

// File: rtl/lcdw_phase_ctrl.sv
module lcdw_phase_ctrl
  import lcdw_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          frameTick,
  input  logic          cascadeIn,
  input  logic [1:0]    extBp1Lvl,
  input  logic [1:0]    extBp2Lvl,
  input  logic          modeIn,
  input  logic          bankIn,
  output phase_strobe_t strobe
);

  logic [1:0] phaseQ;
  logic       runQ;
  logic       extValid;
  logic [1:0] extPhase;
  logic [1:0] ownNext;
  logic       advance;
  logic [1:0] nextPhase;

  // Recover the leader's phase from its backplane levels
  always_comb begin
    extValid = 1'b1;
    extPhase = 2'd0;
    if (extBp1Lvl == LVL_HIGH)      extPhase = 2'd0;
    else if (extBp1Lvl == LVL_LOW)  extPhase = 2'd1;
    else if (extBp2Lvl == LVL_HIGH) extPhase = 2'd2;
    else if (extBp2Lvl == LVL_LOW)  extPhase = 2'd3;
    else                            extValid = 1'b0;
  end

  // Own sequencing: four phases in duplex, two in direct
  always_comb begin
    if (!runQ)       ownNext = 2'd0;
    else if (modeIn) ownNext = phaseQ + 2'd1;
    else             ownNext = (phaseQ == 2'd0) ? 2'd1 : 2'd0;
  end

  assign advance   = cascadeIn ? (extValid && (!runQ || extPhase != phaseQ))
                               : frameTick;
  assign nextPhase = cascadeIn ? extPhase : ownNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= 2'd0;
      runQ   <= 1'b0;
    end else if (advance) begin
      phaseQ <= nextPhase;
      runQ   <= 1'b1;
    end
  end

  always_comb begin
    strobe.advance = advance;
    strobe.phase   = nextPhase;
    strobe.duplex  = modeIn;
    strobe.bank    = bankIn;
  end

endmodule

// File: rtl/lcdw_seg_datapath.sv
module lcdw_seg_datapath
  import lcdw_pkg::*;
#(
  parameter  int NUM_GROUPS = 4,
  parameter  int GROUP_BITS = 8,
  localparam int NUM_REGS   = 2 * NUM_GROUPS,
  localparam int ADDR_W     = $clog2(NUM_REGS),
  localparam int NUM_SEGS   = NUM_GROUPS * GROUP_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  phase_strobe_t         strobe,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [GROUP_BITS-1:0] wrData,
  output logic [2*NUM_SEGS-1:0] segLvl,
  output logic [1:0]            bp1Lvl,
  output logic [1:0]            bp2Lvl
);

  logic [GROUP_BITS-1:0] regFile [NUM_REGS];
  lvl_e                  actLvl;
  lvl_e                  bp1Next;
  lvl_e                  bp2Next;
  logic                  useOdd;
  logic [2*NUM_SEGS-1:0] segNext;
  logic [2*NUM_SEGS-1:0] segQ;
  logic [1:0]            bp1Q;
  logic [1:0]            bp2Q;

  // Pixel storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) regFile[r] <= '0;
    end else if (wrEn && (int'(wrAddr) < NUM_REGS)) begin
      regFile[wrAddr] <= wrData;
    end
  end

  // Backplane levels and register half for the phase being entered
  always_comb begin
    if (strobe.duplex) begin
      useOdd = strobe.phase[1];
      actLvl = strobe.phase[0] ? LVL_LOW : LVL_HIGH;
      if (!strobe.phase[1]) begin
        bp1Next = actLvl;
        bp2Next = LVL_MID;
      end else begin
        bp1Next = LVL_MID;
        bp2Next = actLvl;
      end
    end else begin
      useOdd  = strobe.bank;
      actLvl  = (strobe.phase == 2'd0) ? LVL_HIGH : LVL_LOW;
      bp1Next = actLvl;
      bp2Next = LVL_LOW;
    end
  end

  // One lane per segment: against the active plane when lit, with it when dark
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    for (genvar b = 0; b < GROUP_BITS; b++) begin : g_bit
      localparam int SEG = g * GROUP_BITS + b;
      logic pixel;
      assign pixel = useOdd ? regFile[2*g+1][b] : regFile[2*g][b];
      assign segNext[2*SEG +: 2] = pixel ? flipRail(actLvl) : actLvl;
    end
  end

  // Outputs only move at a phase boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      segQ <= '0;
      bp1Q <= LVL_LOW;
      bp2Q <= LVL_LOW;
    end else if (strobe.advance) begin
      segQ <= segNext;
      bp1Q <= bp1Next;
      bp2Q <= bp2Next;
    end
  end

  assign segLvl = segQ;
  assign bp1Lvl = bp1Q;
  assign bp2Lvl = bp2Q;

endmodule

// File: rtl/lcd_wave_gen.sv
module lcd_wave_gen
  import lcdw_pkg::*;
#(
  parameter  int NUM_GROUPS = 4,
  parameter  int GROUP_BITS = 8,
  localparam int NUM_REGS   = 2 * NUM_GROUPS,
  localparam int ADDR_W     = $clog2(NUM_REGS),
  localparam int NUM_SEGS   = NUM_GROUPS * GROUP_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frameTick,
  input  logic                  cascadeIn,
  input  logic [1:0]            extBp1Lvl,
  input  logic [1:0]            extBp2Lvl,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [GROUP_BITS-1:0] wrData,
  input  logic                  modeIn,
  input  logic                  bankIn,
  output logic [2*NUM_SEGS-1:0] segLvl,
  output logic [1:0]            bp1Lvl,
  output logic [1:0]            bp2Lvl
);

  phase_strobe_t strobe;
  logic [1:0]    bp1Int;
  logic [1:0]    bp2Int;

  lcdw_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .frameTick (frameTick),
    .cascadeIn (cascadeIn),
    .extBp1Lvl (extBp1Lvl),
    .extBp2Lvl (extBp2Lvl),
    .modeIn    (modeIn),
    .bankIn    (bankIn),
    .strobe    (strobe)
  );

  lcdw_seg_datapath #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_BITS (GROUP_BITS)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .segLvl (segLvl),
    .bp1Lvl (bp1Int),
    .bp2Lvl (bp2Int)
  );

  // A follower leaves the shared backplanes to the leader
  assign bp1Lvl = cascadeIn ? LVL_HIZ : bp1Int;
  assign bp2Lvl = cascadeIn ? LVL_HIZ : bp2Int;

endmodule

// File: rtl/lcd_wave_gen_chk.sv
module lcd_wave_gen_chk #(
  parameter int NUM_SEGS = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cascadeIn,
  input logic                  advance,
  input logic [2*NUM_SEGS-1:0] segLvl,
  input logic [1:0]            bp1Lvl,
  input logic [1:0]            bp2Lvl
);

  localparam logic [2*NUM_SEGS-1:0] MID_BITS = {NUM_SEGS{2'b01}};

  // R1: outputs start from the cleared state after reset
  a_r1_segs_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> segLvl == '0);

  a_r1_bp_low: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !cascadeIn) |-> (bp1Lvl == 2'b00 && bp2Lvl == 2'b00));

  // R6: segments use only the two rails
  a_r6_seg_rails: assert property (@(posedge clk) disable iff (rst)
    (segLvl & MID_BITS) == '0);

  // R7: no output movement without a phase advance
  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(segLvl));

  // R9: a follower floats both backplanes
  a_r9_follower_float: assert property (@(posedge clk) disable iff (rst)
    cascadeIn |-> (bp1Lvl == 2'b11 && bp2Lvl == 2'b11));

  // R2: a leader always drives its backplanes
  a_r2_leader_drives: assert property (@(posedge clk) disable iff (rst)
    !cascadeIn |-> (bp1Lvl != 2'b11 && bp2Lvl != 2'b11));

  // R5: only one backplane rests at mid at a time
  a_r5_one_mid: assert property (@(posedge clk) disable iff (rst)
    !(bp1Lvl == 2'b01 && bp2Lvl == 2'b01));

endmodule

bind lcd_wave_gen lcd_wave_gen_chk #(.NUM_SEGS(NUM_SEGS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cascadeIn (cascadeIn),
  .advance   (strobe.advance),
  .segLvl    (segLvl),
  .bp1Lvl    (bp1Lvl),
  .bp2Lvl    (bp2Lvl)
);

// File: tb/lcd_wave_gen_tb.sv
`timescale 1ns/1ps
module lcd_wave_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frameTick = 1'b0;
  logic        cascadeIn = 1'b0;
  logic [1:0]  extBp1Lvl = 2'b11;
  logic [1:0]  extBp2Lvl = 2'b11;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = 3'd0;
  logic [7:0]  wrData = 8'd0;
  logic        modeIn = 1'b0;
  logic        bankIn = 1'b0;
  logic [63:0] segLvl;
  logic [1:0]  bp1Lvl;
  logic [1:0]  bp2Lvl;

  int    compared = 0;
  int    mismatched = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  lcd_wave_gen u_dut (
    .clk(clk), .rst(rst), .frameTick(frameTick), .cascadeIn(cascadeIn),
    .extBp1Lvl(extBp1Lvl), .extBp2Lvl(extBp2Lvl), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .modeIn(modeIn), .bankIn(bankIn),
    .segLvl(segLvl), .bp1Lvl(bp1Lvl), .bp2Lvl(bp2Lvl)
  );

  // ---------------- behavioural reference ----------------
  int          mReg [8];
  int          mPhase;
  bit          mRun;
  logic [63:0] mSeg;
  logic [1:0]  mBp1, mBp2;

  function automatic logic [1:0] otherRail(logic [1:0] l);
    return (l == 2'b10) ? 2'b00 : 2'b10;
  endfunction

  task automatic modelOutputs(int p, bit dup, bit bk);
    logic [1:0] act;
    int half;
    if (dup) begin
      act  = (p % 2 == 0) ? 2'b10 : 2'b00;
      half = (p >= 2) ? 1 : 0;
      mBp1 = (p < 2) ? act : 2'b01;
      mBp2 = (p < 2) ? 2'b01 : act;
    end else begin
      act  = (p == 0) ? 2'b10 : 2'b00;
      half = bk ? 1 : 0;
      mBp1 = act;
      mBp2 = 2'b00;
    end
    for (int s = 0; s < 32; s++) begin
      int r;
      bit lit;
      r = 2 * (s / 8) + half;
      lit = ((mReg[r] >> (s % 8)) & 1) == 1;
      mSeg[2*s +: 2] = lit ? otherRail(act) : act;
    end
  endtask

  always @(posedge clk) begin : ref_model
    bit adv;
    int np;
    if (rst) begin
      for (int r = 0; r < 8; r++) mReg[r] = 0;
      mPhase = 0;
      mRun = 1'b0;
      mSeg = '0;
      mBp1 = 2'b00;
      mBp2 = 2'b00;
    end else begin
      adv = 1'b0;
      np = 0;
      if (cascadeIn) begin
        if (extBp1Lvl == 2'b10)      begin np = 0; adv = 1'b1; end
        else if (extBp1Lvl == 2'b00) begin np = 1; adv = 1'b1; end
        else if (extBp2Lvl == 2'b10) begin np = 2; adv = 1'b1; end
        else if (extBp2Lvl == 2'b00) begin np = 3; adv = 1'b1; end
        if (mRun && np == mPhase) adv = 1'b0;
      end else begin
        adv = frameTick;
        if (!mRun)       np = 0;
        else if (modeIn) np = (mPhase + 1) % 4;
        else             np = (mPhase == 0) ? 1 : 0;
      end
      if (adv) begin
        modelOutputs(np, modeIn, bankIn);
        mPhase = np;
        mRun = 1'b1;
      end
      if (wrEn) mReg[wrAddr] = int'(wrData);
    end
  end

  // ---------------- every-cycle comparison ----------------
  task automatic compareVal(string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      compareVal("segments", segLvl, mSeg);
      compareVal("backplane1", 64'(bp1Lvl), 64'(cascadeIn ? 2'b11 : mBp1));
      compareVal("backplane2", 64'(bp2Lvl), 64'(cascadeIn ? 2'b11 : mBp2));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic tick();
    frameTick = 1'b1;
    step();
    frameTick = 1'b0;
  endtask

  task automatic wr(int a, int d);
    wrEn = 1'b1;
    wrAddr = 3'(a);
    wrData = 8'(d);
    step();
    wrEn = 1'b0;
  endtask

  task automatic spot(string req, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    idle(4);
    @(negedge clk);
    spot("R1", "reset segments", segLvl, 64'd0);
    spot("R1", "reset backplane1", 64'(bp1Lvl), 64'd0);
    rst = 1'b0;
    idle(2);

    // R10 / R1: first advance enters phase 0 with cleared registers
    curReq = "R10";
    tick();
    @(negedge clk);
    spot("R10", "first phase backplane1", 64'(bp1Lvl), 64'(2'b10));
    spot("R1", "cleared regs all dark", segLvl, {32{2'b10}});
    idle(2);

    // R8: writes alone leave outputs alone
    curReq = "R8";
    wr(0, 'hA5); wr(1, 'h3C); wr(2, 'h01); wr(3, 'h80);
    wr(4, 'hFF); wr(5, 'h00); wr(6, 'h10); wr(7, 'h7E);
    @(negedge clk);
    spot("R8", "no change before advance", segLvl, {32{2'b10}});
    idle(1);

    // R3 / R2: direct drive, page 0, phase 1
    curReq = "R3";
    tick();
    @(negedge clk);
    spot("R2", "direct backplane1 low", 64'(bp1Lvl), 64'(2'b00));
    spot("R2", "direct backplane2 low", 64'(bp2Lvl), 64'(2'b00));
    spot("R3", "lit seg0 opposite", 64'(segLvl[1:0]), 64'(2'b10));
    spot("R3", "dark seg1 same", 64'(segLvl[3:2]), 64'(2'b00));
    idle(2);
    curReq = "R2";
    repeat (3) begin tick(); idle(3); end

    // R7: page change waits for the advance
    curReq = "R7";
    bankIn = 1'b1;
    idle(4);
    curReq = "R4";
    tick();
    @(negedge clk);
    spot("R4", "page1 seg15 lit", 64'(segLvl[31:30]), 64'(2'b10));
    spot("R4", "page1 seg8 dark", 64'(segLvl[17:16]), 64'(2'b00));
    spot("R4", "page1 seg7 dark", 64'(segLvl[15:14]), 64'(2'b00));
    idle(2);
    repeat (2) begin tick(); idle(2); end

    // R5 / R6: duplex from phase 1 enters phase 2
    curReq = "R5";
    modeIn = 1'b1;
    bankIn = 1'b0;
    tick();
    @(negedge clk);
    spot("R5", "duplex phase2 backplane1 mid", 64'(bp1Lvl), 64'(2'b01));
    spot("R5", "duplex phase2 backplane2 high", 64'(bp2Lvl), 64'(2'b10));
    spot("R6", "odd reg seg0 dark", 64'(segLvl[1:0]), 64'(2'b10));
    spot("R6", "odd reg seg2 lit", 64'(segLvl[5:4]), 64'(2'b00));
    idle(2);
    curReq = "R6";
    tick(); idle(2);
    bankIn = 1'b1;
    tick(); idle(2);
    tick(); idle(2);
    bankIn = 1'b0;
    wr(5, 'hC3);
    tick(); idle(2);
    tick(); idle(2);

    // R10: direct from duplex phase 3 lands on phase 0
    curReq = "R10";
    modeIn = 1'b0;
    tick();
    @(negedge clk);
    spot("R10", "direct re-entry backplane1", 64'(bp1Lvl), 64'(2'b10));
    spot("R10", "direct re-entry backplane2", 64'(bp2Lvl), 64'(2'b00));
    idle(2);

    // R9: follower operation
    curReq = "R9";
    cascadeIn = 1'b1;
    modeIn = 1'b1;
    extBp1Lvl = 2'b10; extBp2Lvl = 2'b01;
    step();
    @(negedge clk);
    spot("R9", "follower backplane1 floats", 64'(bp1Lvl), 64'(2'b11));
    idle(2);
    tick(); idle(2);
    extBp1Lvl = 2'b00; idle(3);
    extBp1Lvl = 2'b01; extBp2Lvl = 2'b10;
    idle(2);
    @(negedge clk);
    spot("R9", "follower phase2 seg0", 64'(segLvl[1:0]), 64'(2'b10));
    idle(1);
    extBp2Lvl = 2'b00; idle(3);
    extBp1Lvl = 2'b11; extBp2Lvl = 2'b11; idle(3);
    tick(); idle(2);
    modeIn = 1'b0;
    extBp1Lvl = 2'b10; extBp2Lvl = 2'b00; idle(3);
    extBp1Lvl = 2'b00; idle(3);

    // R1: reset while following floats the backplanes
    curReq = "R1";
    rst = 1'b1;
    idle(2);
    @(negedge clk);
    spot("R1", "follower reset backplane1", 64'(bp1Lvl), 64'(2'b11));
    spot("R1", "follower reset segments", segLvl, 64'd0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule